// File: doc/BRIEF.md
# DMA Channel Descriptor Sequencer

This block is the control state machine for a single DMA channel. It owns the channel's run state, reported as disabled, enabled or paused, and the current source and destination descriptor pointers. It also holds the working copies of the descriptors the data mover is using. It fetches descriptors from memory through a request/response port, or takes them from descriptor registers when register mode is selected. After each fetch it starts the data mover, and when the mover reports a finished source descriptor it acts on that descriptor's command field.

Software drives the channel through one control write strobe. The strobe carries enable, continue, continue-from-start and register-mode bits. A halt command parks the channel in the paused state. From there a write with continue set resumes the channel, either at the next source descriptor or from the programmed start addresses. A stop command, or any completion in register mode, turns the channel off. The data mover can also ask for the next destination descriptor in the middle of a transfer.

Descriptor layout, 128 bits with word 0 in the lowest 32 bits:
- bits 63:0 hold the buffer address.
- bits 93:64 hold the size.
- bit 96 is the coherent flag.
- bit 97 is the type: 0 is linear, 1 is linked.
- bit 98 is the interrupt flag.
- bits 100:99 hold the command (source side): 1 is halt, 2 is stop, 0 and 3 mean continue.

Top module: `dma_chan_ctrl`

## Requirements
- R1: `ch_status` reads 0 when disabled, 1 when enabled and 2 when paused. It reads 3 whenever the error flag is set, whatever the run state. A disabled channel issues no fetch and no mover start.
- R2: A control write with enable set while disabled loads `src_ptr` and `dst_ptr` from `src_start` and `dst_start` and enters enabled. It then fetches the destination descriptor, then the source descriptor, and pulses `mover_start` with both descriptors on the mover outputs.
- R3: In register mode no fetch is requested; the descriptors come from `reg_src_desc` and `reg_dst_desc`. Every source completion clears enable and disables the channel, whatever the command. The mode bit is taken only from a write made while disabled.
- R4: A completed source descriptor with command 2 (stop) clears enable and disables the channel.
- R5: A completed source descriptor with command 1 (halt) pauses the channel without moving `src_ptr` and pulses `evt_pause` for one cycle.
- R6: A completed source descriptor with command 0 or 3 and type linear (bit 97 = 0) advances `src_ptr` by 16 and fetches the next source descriptor there.
- R7: When the consumed descriptor is linked (bit 97 = 1), the block requests an 8-byte pointer read (`fetch_ptr_only` = 1) at the pointer plus 16. The low 64 bits of the response replace the pointer, and the next descriptor is fetched from it.
- R8: A write with enable and continue set while paused, with continue-from-start 0, advances `src_ptr` according to the held source descriptor's type, clears `ch_cont` and returns to enabled.
- R9: The same resume with continue-from-start 1 reloads both pointers from the start inputs and refetches the destination descriptor before the source descriptor.
- R10: A write with enable clear and continue set while paused disables the channel. A write with both clear leaves it paused.
- R11: A fetch at an address that is not 16-byte aligned is never requested. Instead the error flag is set, the channel is disabled and a one-cycle read-error event is raised (`evt_src_rd_err` or `evt_dst_rd_err`). The next write with enable set clears the error.
- R12: Only one fetch is outstanding. `fetch_req` stays high with a stable `fetch_addr` until `fetch_rsp_valid`, and `mover_start` comes only after the source descriptor has arrived.
- R13: In memory mode, `mover_dst_next` during a transfer advances `dst_ptr` according to the destination descriptor's type and fetches the new destination descriptor, then pulses `mover_dst_upd`. In register mode it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Written channel enable |
| ctrl_cont | input | 1 | Written continue bit |
| ctrl_from_start | input | 1 | Written continue-from-start bit |
| ctrl_reg_mode | input | 1 | Written register-mode bit |
| src_start | input | PTR_W | Source chain start address |
| dst_start | input | PTR_W | Destination chain start address |
| reg_src_desc | input | 128 | Register-held source descriptor |
| reg_dst_desc | input | 128 | Register-held destination descriptor |
| fetch_req | output | 1 | Fetch request, held until response |
| fetch_ptr_only | output | 1 | 1: 8-byte next-pointer read, 0: 16-byte descriptor read |
| fetch_addr | output | PTR_W | Fetch address |
| fetch_rsp_valid | input | 1 | Fetch response valid |
| fetch_rsp_data | input | 128 | Fetch response data |
| mover_start | output | 1 | One-cycle start to the data mover |
| mover_src_desc | output | 128 | Current source descriptor |
| mover_dst_desc | output | 128 | Current destination descriptor |
| mover_dst_upd | output | 1 | New destination descriptor loaded mid-transfer |
| mover_dst_next | input | 1 | Mover asks for the next destination descriptor |
| mover_done | input | 1 | Mover finished the source descriptor |
| ch_status | output | 2 | Channel state code |
| ch_en | output | 1 | Enable bit |
| ch_cont | output | 1 | Continue bit |
| src_ptr | output | PTR_W | Current source descriptor pointer |
| dst_ptr | output | PTR_W | Current destination descriptor pointer |
| evt_pause | output | 1 | Pause event pulse |
| evt_src_rd_err | output | 1 | Source descriptor read error pulse |
| evt_dst_rd_err | output | 1 | Destination descriptor read error pulse |

## Verification
A control write takes effect at the clock edge that samples it, and the new status, pointers and continue bit are visible one cycle later. A fetch request appears combinationally in the cycle after the state enters a fetch state. A response moves the state on at the edge that samples it, so `mover_start` and `mover_dst_upd` are already high in the cycle right after that response. A misaligned pointer turns into error status and an error pulse one edge after the fetch state is entered. The bench drives inputs on the falling edge and samples outputs on the falling edge after each such edge. Each task waits for a request with a bounded loop before it answers, and checks results exactly one edge after the stimulus.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    localparam int DESC_W       = 128;
    localparam int DESC_BYTES   = 16;
    localparam int ALIGN_LOG2   = 4;
    localparam int TYPE_BIT     = 97;
    localparam int CMD_LSB      = 99;

    localparam logic [1:0] CMD_HALT = 2'd1;
    localparam logic [1:0] CMD_STOP = 2'd2;

    localparam logic [1:0] STAT_OFF   = 2'd0;
    localparam logic [1:0] STAT_RUN   = 2'd1;
    localparam logic [1:0] STAT_PAUSE = 2'd2;
    localparam logic [1:0] STAT_ERR   = 2'd3;

    typedef enum logic [2:0] {
        S_OFF    = 3'd0,
        S_DFETCH = 3'd1,
        S_SFETCH = 3'd2,
        S_NPTR   = 3'd3,
        S_MOVE   = 3'd4,
        S_PAUSE  = 3'd5
    } dcc_state_e;

    function automatic logic desc_linked(input logic [DESC_W-1:0] d);
        return d[TYPE_BIT];
    endfunction

    function automatic logic [1:0] desc_cmd(input logic [DESC_W-1:0] d);
        return d[CMD_LSB +: 2];
    endfunction

endpackage

// File: rtl/dcc_ptr_step.sv
module dcc_ptr_step #(
    parameter int PTR_W      = 64,
    parameter int STEP_BYTES = 16,
    parameter int ALIGN_LOG2 = 4
) (
    input  logic [PTR_W-1:0] ptr_i,
    output logic [PTR_W-1:0] ptr_next_o,
    output logic             aligned_o
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(STEP_BYTES);

    assign ptr_next_o = ptr_i + STEP;
    assign aligned_o  = (ptr_i[ALIGN_LOG2-1:0] == '0);
endmodule

// File: rtl/dcc_status_enc.sv
module dcc_status_enc
    import dcc_pkg::*;
(
    input  dcc_state_e state_i,
    input  logic       err_i,
    output logic [1:0] status_o
);
    always_comb begin
        if (err_i)                   status_o = STAT_ERR;
        else if (state_i == S_OFF)   status_o = STAT_OFF;
        else if (state_i == S_PAUSE) status_o = STAT_PAUSE;
        else                         status_o = STAT_RUN;
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dcc_pkg::*;
#(
    parameter int PTR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_en,
    input  logic              ctrl_cont,
    input  logic              ctrl_from_start,
    input  logic              ctrl_reg_mode,
    input  logic [PTR_W-1:0]  src_start,
    input  logic [PTR_W-1:0]  dst_start,
    input  logic [127:0]      reg_src_desc,
    input  logic [127:0]      reg_dst_desc,
    output logic              fetch_req,
    output logic              fetch_ptr_only,
    output logic [PTR_W-1:0]  fetch_addr,
    input  logic              fetch_rsp_valid,
    input  logic [127:0]      fetch_rsp_data,
    output logic              mover_start,
    output logic [127:0]      mover_src_desc,
    output logic [127:0]      mover_dst_desc,
    output logic              mover_dst_upd,
    input  logic              mover_dst_next,
    input  logic              mover_done,
    output logic [1:0]        ch_status,
    output logic              ch_en,
    output logic              ch_cont,
    output logic [PTR_W-1:0]  src_ptr,
    output logic [PTR_W-1:0]  dst_ptr,
    output logic              evt_pause,
    output logic              evt_src_rd_err,
    output logic              evt_dst_rd_err
);
    localparam int NCHAIN = 2;
    localparam int CH_SRC = 0;
    localparam int CH_DST = 1;

    typedef struct packed {
        dcc_state_e        state;
        logic              err;
        logic              en;
        logic              cont;
        logic              from_start;
        logic              reg_mode;
        logic              chain_dst;
        logic              dst_mid;
        logic              start;
        logic              dst_upd;
        logic              pause_evt;
        logic              src_err;
        logic              dst_err;
        logic [PTR_W-1:0]  src_ptr;
        logic [PTR_W-1:0]  dst_ptr;
        logic [DESC_W-1:0] src_desc;
        logic [DESC_W-1:0] dst_desc;
    } ch_t;

    ch_t q, d;

    // Per-chain pointer arithmetic
    logic [PTR_W-1:0] cptr  [NCHAIN];
    logic [PTR_W-1:0] cstep [NCHAIN];
    logic             cal   [NCHAIN];

    assign cptr[CH_SRC] = q.src_ptr;
    assign cptr[CH_DST] = q.dst_ptr;

    for (genvar g = 0; g < NCHAIN; g++) begin : g_chain
        dcc_ptr_step #(
            .PTR_W     (PTR_W),
            .STEP_BYTES(DESC_BYTES),
            .ALIGN_LOG2(ALIGN_LOG2)
        ) u_step (
            .ptr_i     (cptr[g]),
            .ptr_next_o(cstep[g]),
            .aligned_o (cal[g])
        );
    end

    logic nptr_al;
    assign nptr_al = q.chain_dst ? cal[CH_DST] : cal[CH_SRC];

    always_comb begin
        d           = q;
        d.start     = 1'b0;
        d.dst_upd   = 1'b0;
        d.pause_evt = 1'b0;
        d.src_err   = 1'b0;
        d.dst_err   = 1'b0;

        // Control write and the actions it triggers
        if (ctrl_wr) begin
            d.en         = ctrl_en;
            d.cont       = ctrl_cont;
            d.from_start = ctrl_from_start;
            if (q.state == S_OFF) d.reg_mode = ctrl_reg_mode;
            if (ctrl_en) begin
                d.err = 1'b0;
                if (q.state == S_PAUSE && ctrl_cont) begin
                    d.cont = 1'b0;
                    if (ctrl_from_start) begin
                        d.src_ptr = src_start;
                        d.dst_ptr = dst_start;
                        d.dst_mid = 1'b0;
                        d.state   = S_DFETCH;
                    end else if (desc_linked(q.src_desc)) begin
                        d.chain_dst = 1'b0;
                        d.state     = S_NPTR;
                    end else begin
                        d.src_ptr = cstep[CH_SRC];
                        d.state   = S_SFETCH;
                    end
                end else if (q.state == S_OFF) begin
                    d.src_ptr = src_start;
                    d.dst_ptr = dst_start;
                    d.dst_mid = 1'b0;
                    d.state   = S_DFETCH;
                end
            end else if (q.state == S_PAUSE && ctrl_cont) begin
                d.state = S_OFF;
            end
        end

        // Sequencing of the busy states
        case (q.state)
            S_DFETCH: begin
                if (q.reg_mode || (cal[CH_DST] && fetch_rsp_valid)) begin
                    d.dst_desc = q.reg_mode ? reg_dst_desc : fetch_rsp_data;
                    if (q.dst_mid) begin
                        d.state   = S_MOVE;
                        d.dst_upd = 1'b1;
                    end else begin
                        d.state = S_SFETCH;
                    end
                end else if (!cal[CH_DST]) begin
                    d.err     = 1'b1;
                    d.dst_err = 1'b1;
                    d.state   = S_OFF;
                end
            end
            S_SFETCH: begin
                if (q.reg_mode || (cal[CH_SRC] && fetch_rsp_valid)) begin
                    d.src_desc = q.reg_mode ? reg_src_desc : fetch_rsp_data;
                    d.state    = S_MOVE;
                    d.start    = 1'b1;
                end else if (!cal[CH_SRC]) begin
                    d.err     = 1'b1;
                    d.src_err = 1'b1;
                    d.state   = S_OFF;
                end
            end
            S_NPTR: begin
                if (!nptr_al) begin
                    d.err     = 1'b1;
                    d.src_err = !q.chain_dst;
                    d.dst_err = q.chain_dst;
                    d.state   = S_OFF;
                end else if (fetch_rsp_valid) begin
                    if (q.chain_dst) begin
                        d.dst_ptr = fetch_rsp_data[PTR_W-1:0];
                        d.state   = S_DFETCH;
                    end else begin
                        d.src_ptr = fetch_rsp_data[PTR_W-1:0];
                        d.state   = S_SFETCH;
                    end
                end
            end
            S_MOVE: begin
                if (mover_dst_next && !q.reg_mode) begin
                    d.dst_mid = 1'b1;
                    if (desc_linked(q.dst_desc)) begin
                        d.chain_dst = 1'b1;
                        d.state     = S_NPTR;
                    end else begin
                        d.dst_ptr = cstep[CH_DST];
                        d.state   = S_DFETCH;
                    end
                end else if (mover_done) begin
                    d.dst_mid = 1'b0;
                    if (q.reg_mode || desc_cmd(q.src_desc) == CMD_STOP) begin
                        d.en    = 1'b0;
                        d.state = S_OFF;
                    end else if (desc_cmd(q.src_desc) == CMD_HALT) begin
                        d.state     = S_PAUSE;
                        d.pause_evt = 1'b1;
                    end else if (desc_linked(q.src_desc)) begin
                        d.chain_dst = 1'b0;
                        d.state     = S_NPTR;
                    end else begin
                        d.src_ptr = cstep[CH_SRC];
                        d.state   = S_SFETCH;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Fetch port
    always_comb begin
        fetch_req      = 1'b0;
        fetch_ptr_only = 1'b0;
        fetch_addr     = '0;
        case (q.state)
            S_DFETCH: begin
                fetch_req  = !q.reg_mode && cal[CH_DST];
                fetch_addr = q.dst_ptr;
            end
            S_SFETCH: begin
                fetch_req  = !q.reg_mode && cal[CH_SRC];
                fetch_addr = q.src_ptr;
            end
            S_NPTR: begin
                fetch_req      = nptr_al;
                fetch_ptr_only = 1'b1;
                fetch_addr     = q.chain_dst ? cstep[CH_DST] : cstep[CH_SRC];
            end
            default: ;
        endcase
    end

    dcc_status_enc u_stat (
        .state_i (q.state),
        .err_i   (q.err),
        .status_o(ch_status)
    );

    logic reg_mode_w;
    assign reg_mode_w     = q.reg_mode;

    assign mover_start    = q.start;
    assign mover_src_desc = q.src_desc;
    assign mover_dst_desc = q.dst_desc;
    assign mover_dst_upd  = q.dst_upd;
    assign ch_en          = q.en;
    assign ch_cont        = q.cont;
    assign src_ptr        = q.src_ptr;
    assign dst_ptr        = q.dst_ptr;
    assign evt_pause      = q.pause_evt;
    assign evt_src_rd_err = q.src_err;
    assign evt_dst_rd_err = q.dst_err;

endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
    parameter int PTR_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_req,
    input logic             fetch_rsp_valid,
    input logic [PTR_W-1:0] fetch_addr,
    input logic [1:0]       ch_status,
    input logic             mover_start,
    input logic             evt_pause,
    input logic             ctrl_wr,
    input logic             ctrl_en,
    input logic             ctrl_cont,
    input logic             reg_mode
);
    // R12
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_rsp_valid |=> fetch_req && $stable(fetch_addr));

    // R11
    fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> fetch_addr[3:0] == 4'h0);

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_status == 2'd0 |-> !fetch_req && !mover_start);

    // R3
    reg_mode_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_mode |-> !fetch_req);

    // R5
    pause_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pause |-> ch_status == 2'd2);

    // R2
    start_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mover_start |-> ch_status == 2'd1);

    // R10
    pause_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !ctrl_en && ctrl_cont && ch_status == 2'd2 |=> ch_status == 2'd0);
endmodule

bind dma_chan_ctrl dcc_chk #(.PTR_W(PTR_W)) u_dcc_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_req      (fetch_req),
    .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_addr     (fetch_addr),
    .ch_status      (ch_status),
    .mover_start    (mover_start),
    .evt_pause      (evt_pause),
    .ctrl_wr        (ctrl_wr),
    .ctrl_en        (ctrl_en),
    .ctrl_cont      (ctrl_cont),
    .reg_mode       (reg_mode_w)
);

// File: tb/dma_chan_ctrl_bench.sv
module dma_chan_ctrl_bench;
    localparam int PW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 0, ctrl_en = 0, ctrl_cont = 0, ctrl_from_start = 0, ctrl_reg_mode = 0;
    logic [PW-1:0] src_start = '0, dst_start = '0;
    logic [127:0]  reg_src_desc = '0, reg_dst_desc = '0;
    logic          fetch_req, fetch_ptr_only;
    logic [PW-1:0] fetch_addr;
    logic          fetch_rsp_valid = 0;
    logic [127:0]  fetch_rsp_data = '0;
    logic          mover_start, mover_dst_upd;
    logic [127:0]  mover_src_desc, mover_dst_desc;
    logic          mover_dst_next = 0, mover_done = 0;
    logic [1:0]    ch_status;
    logic          ch_en, ch_cont;
    logic [PW-1:0] src_ptr, dst_ptr;
    logic          evt_pause, evt_src_rd_err, evt_dst_rd_err;

    int n_chk = 0;
    int n_fail = 0;
    int fetch_seen = 0;
    bit mon_en = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_chan_ctrl #(.PTR_W(PW)) u_dma_chan_ctrl (.*);

    always @(negedge clk) if (mon_en && fetch_req) fetch_seen++;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_desc(input logic [63:0] a, input logic [29:0] sz,
                                             input logic linked, input logic [1:0] cmd);
        logic [127:0] v = '0;
        v[63:0]   = a;
        v[93:64]  = sz;
        v[97]     = linked;
        v[100:99] = cmd;
        return v;
    endfunction

    task automatic wr_ctrl(input logic en, input logic cont, input logic fs, input logic rm);
        ctrl_wr = 1; ctrl_en = en; ctrl_cont = cont; ctrl_from_start = fs; ctrl_reg_mode = rm;
        @(negedge clk);
        ctrl_wr = 0;
    endtask

    task automatic serve(input string req, input logic [63:0] addr, input logic ponly,
                         input logic [127:0] data);
        int i;
        for (i = 0; i < 20 && !fetch_req; i++) @(negedge clk);
        chk({req, " fetch request"}, fetch_req, 1'b1);
        chk({req, " fetch address"}, fetch_addr, addr);
        chk({req, " fetch kind"}, fetch_ptr_only, ponly);
        fetch_rsp_valid = 1; fetch_rsp_data = data;
        @(negedge clk);
        fetch_rsp_valid = 0;
    endtask

    task automatic wait_start(input string req);
        int i;
        for (i = 0; i < 20 && !mover_start; i++) @(negedge clk);
        chk({req, " mover start"}, mover_start, 1'b1);
    endtask

    task automatic pulse_done();
        mover_done = 1;
        @(negedge clk);
        mover_done = 0;
    endtask

    task automatic t_reset();
        chk("R1 reset status", ch_status, 2'd0);
        chk("R1 reset fetch_req", fetch_req, 1'b0);
        chk("R1 reset enable", ch_en, 1'b0);
    endtask

    // R2 R6 R12 R4
    task automatic t_linear_run();
        logic [127:0] sd = mk_desc(64'hA000, 30'd64, 1'b0, 2'd0);
        int starts = 0;
        src_start = 64'h1000; dst_start = 64'h2000;
        wr_ctrl(1, 0, 0, 0);
        chk("R2 status enabled", ch_status, 2'd1);
        chk("R2 src_ptr loaded", src_ptr, 64'h1000);
        chk("R2 dst_ptr loaded", dst_ptr, 64'h2000);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (mover_start) starts++;
        end
        chk("R12 request held", fetch_req, 1'b1);
        chk("R12 address stable", fetch_addr, 64'h2000);
        chk("R12 no start before descriptors", starts, 0);
        serve("R2 dst", 64'h2000, 0, mk_desc(64'h9000, 30'd64, 1'b0, 2'd0));
        serve("R2 src", 64'h1000, 0, sd);
        wait_start("R2");
        chk("R2 src descriptor to mover", mover_src_desc, sd);
        chk("R2 dst descriptor to mover", mover_dst_desc[63:0], 64'h9000);
        pulse_done();
        chk("R6 src_ptr advanced by 16", src_ptr, 64'h1010);
        serve("R6 next src", 64'h1010, 0, mk_desc(64'hB000, 30'd8, 1'b0, 2'd2));
        wait_start("R6");
        pulse_done();
        chk("R4 stop disables", ch_status, 2'd0);
        chk("R4 stop clears enable", ch_en, 1'b0);
    endtask

    // R5 R8 R10
    task automatic t_pause_resume();
        src_start = 64'h1000; dst_start = 64'h2000;
        wr_ctrl(1, 0, 0, 0);
        serve("R5 dst", 64'h2000, 0, mk_desc(64'h9000, 30'd4, 1'b0, 2'd0));
        serve("R5 src", 64'h1000, 0, mk_desc(64'hA000, 30'd4, 1'b0, 2'd1));
        wait_start("R5");
        pulse_done();
        chk("R5 halt pauses", ch_status, 2'd2);
        chk("R5 pause event", evt_pause, 1'b1);
        chk("R5 src_ptr held", src_ptr, 64'h1000);
        @(negedge clk);
        chk("R5 pause event one cycle", evt_pause, 1'b0);
        wr_ctrl(0, 0, 0, 0);
        chk("R10 no continue stays paused", ch_status, 2'd2);
        wr_ctrl(1, 1, 0, 0);
        chk("R8 resume enabled", ch_status, 2'd1);
        chk("R8 continue self-clears", ch_cont, 1'b0);
        chk("R8 src_ptr advanced", src_ptr, 64'h1010);
        serve("R8 next src", 64'h1010, 0, mk_desc(64'hA100, 30'd4, 1'b0, 2'd1));
        wait_start("R8");
        pulse_done();
        chk("R8 paused again", ch_status, 2'd2);
        wr_ctrl(0, 1, 0, 0);
        chk("R10 leave pause to disabled", ch_status, 2'd0);
    endtask

    // R9
    task automatic t_from_start();
        src_start = 64'h1000; dst_start = 64'h2000;
        wr_ctrl(1, 0, 0, 0);
        serve("R9 dst", 64'h2000, 0, mk_desc(64'h9000, 30'd4, 1'b0, 2'd0));
        serve("R9 src", 64'h1000, 0, mk_desc(64'hA000, 30'd4, 1'b0, 2'd1));
        wait_start("R9");
        pulse_done();
        src_start = 64'h3000; dst_start = 64'h4000;
        wr_ctrl(1, 1, 1, 0);
        chk("R9 src reload", src_ptr, 64'h3000);
        chk("R9 dst reload", dst_ptr, 64'h4000);
        serve("R9 dst refetch", 64'h4000, 0, mk_desc(64'h9900, 30'd4, 1'b0, 2'd0));
        serve("R9 src refetch", 64'h3000, 0, mk_desc(64'hA000, 30'd4, 1'b0, 2'd2));
        wait_start("R9 restart");
        pulse_done();
        chk("R9 stop after restart", ch_status, 2'd0);
    endtask

    // R7
    task automatic t_linked();
        src_start = 64'h1000; dst_start = 64'h2000;
        wr_ctrl(1, 0, 0, 0);
        serve("R7 dst", 64'h2000, 0, mk_desc(64'h9000, 30'd4, 1'b0, 2'd0));
        serve("R7 src", 64'h1000, 0, mk_desc(64'hA000, 30'd4, 1'b1, 2'd0));
        wait_start("R7");
        pulse_done();
        serve("R7 next pointer", 64'h1010, 1, 128'h5540);
        chk("R7 src_ptr from memory", src_ptr, 64'h5540);
        serve("R7 linked src", 64'h5540, 0, mk_desc(64'hA000, 30'd4, 1'b0, 2'd2));
        wait_start("R7 linked");
        pulse_done();
        chk("R7 stop", ch_status, 2'd0);
    endtask

    // R13
    task automatic t_dst_next();
        logic [127:0] nd = mk_desc(64'h9400, 30'd32, 1'b0, 2'd0);
        src_start = 64'h1000; dst_start = 64'h2000;
        wr_ctrl(1, 0, 0, 0);
        serve("R13 dst", 64'h2000, 0, mk_desc(64'h9000, 30'd4, 1'b0, 2'd0));
        serve("R13 src", 64'h1000, 0, mk_desc(64'hA000, 30'd64, 1'b0, 2'd2));
        wait_start("R13");
        mover_dst_next = 1;
        @(negedge clk);
        mover_dst_next = 0;
        chk("R13 dst_ptr advanced", dst_ptr, 64'h2010);
        serve("R13 next dst", 64'h2010, 0, nd);
        chk("R13 dst update pulse", mover_dst_upd, 1'b1);
        chk("R13 new dst descriptor", mover_dst_desc, nd);
        pulse_done();
        chk("R13 done stops", ch_status, 2'd0);
    endtask

    // R3
    task automatic t_reg_mode();
        int ups = 0;
        reg_src_desc = mk_desc(64'hC000, 30'd16, 1'b0, 2'd0);
        reg_dst_desc = mk_desc(64'hD000, 30'd16, 1'b0, 2'd0);
        fetch_seen = 0; mon_en = 1;
        wr_ctrl(1, 0, 0, 1);
        wait_start("R3");
        chk("R3 src from register", mover_src_desc, reg_src_desc);
        chk("R3 dst from register", mover_dst_desc, reg_dst_desc);
        mover_dst_next = 1;
        @(negedge clk);
        mover_dst_next = 0;
        for (int k = 0; k < 3; k++) begin
            if (mover_dst_upd) ups++;
            @(negedge clk);
        end
        chk("R13 dst next ignored in register mode", ups, 0);
        chk("R13 dst_ptr unchanged in register mode", dst_ptr, 64'h2000);
        pulse_done();
        chk("R3 completion disables", ch_status, 2'd0);
        chk("R3 completion clears enable", ch_en, 1'b0);
        mon_en = 0;
        chk("R3 no fetch in register mode", fetch_seen, 0);
        wr_ctrl(0, 0, 0, 0);
    endtask

    // R11 R1
    task automatic t_misalign();
        src_start = 64'h1008; dst_start = 64'h2000;
        wr_ctrl(1, 0, 0, 0);
        serve("R11 dst", 64'h2000, 0, mk_desc(64'h9000, 30'd4, 1'b0, 2'd0));
        chk("R11 misaligned not requested", fetch_req, 1'b0);
        @(negedge clk);
        chk("R1 error status", ch_status, 2'd3);
        chk("R11 source read error event", evt_src_rd_err, 1'b1);
        @(negedge clk);
        chk("R11 error event one cycle", evt_src_rd_err, 1'b0);
        src_start = 64'h1000;
        wr_ctrl(1, 0, 0, 0);
        chk("R11 enable clears error", ch_status, 2'd1);
        serve("R11 dst again", 64'h2000, 0, mk_desc(64'h9000, 30'd4, 1'b0, 2'd0));
        serve("R11 src again", 64'h1000, 0, mk_desc(64'hA000, 30'd4, 1'b0, 2'd2));
        wait_start("R11");
        pulse_done();
        chk("R11 clean stop", ch_status, 2'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_linear_run();
        t_pause_resume();
        t_from_start();
        t_linked();
        t_dst_next();
        t_reg_mode();
        t_misalign();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule